// File: doc/BRIEF.md
# Tiled-View Address Translator

This block turns a pixel coordinate into a 32-bit address inside a two-dimensional tiled container. A request carries a pixel format, an orientation code and unsigned X and Y coordinates. The block checks the coordinate against the range that the format allows. It then applies per-axis mirroring and an optional X/Y swap, scales the resulting linear index by the format's element size, and places the format and orientation codes in the top address bits. It also reports the row stride of the selected view, so a client can step from one line to the next.

The path has one register stage. A request presented with `req_valid` high at a rising clock edge shows up on the outputs after that edge, with `rsp_valid` high. When no request is presented, the outputs keep their last values. Requests in page format, and coordinates outside the format's range, give a response with `rsp_ok` low and address zero.

Top module: `tiled_view_xlate`

## Requirements
- R1: `rsp_valid` is high in the cycle after an edge at which `req_valid` was high, and low after an edge at which it was low. While reset is active, `rsp_valid`, `rsp_ok`, `rsp_addr` and `rsp_stride` are all zero.
- R2: For an accepted request, address bits [28:27] carry the format code: 0 selects 8-bit, 1 selects 16-bit, 2 selects 32-bit elements.
- R3: For an accepted request, address bits [31:29] carry the orientation code unchanged. Bit 0 of that code mirrors X, bit 1 mirrors Y and bit 2 swaps the axes.
- R4: The format drops (xd, yd) low coordinate bits: (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit. X may use 14−xd bits and Y may use 13−yd bits. A coordinate above its axis mask gives `rsp_ok` low and `rsp_addr` zero.
- R5: Format code 3 (page) is always rejected: `rsp_ok` low, `rsp_addr` zero and `rsp_stride` zero.
- R6: With the X mirror bit set, X is XORed with the X mask before indexing. With the Y mirror bit set, Y is XORed with the Y mask.
- R7: Without the swap bit the linear index is Y·2^(X bits) + X. With the swap bit it is X·2^(Y bits) + Y.
- R8: The linear index is shifted left by xd+yd and fills address bits [26:0].
- R9: For formats 0 to 2, `rsp_stride` is 2^(13+xd) when the swap bit is set and 2^(14+yd) otherwise. This holds for in-range and out-of-range coordinates alike.
- R10: An edge with `req_valid` low leaves `rsp_ok`, `rsp_addr` and `rsp_stride` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_fmt | input | 2 | Pixel format code |
| req_orient | input | 3 | Orientation code (mirror X, mirror Y, swap) |
| req_x | input | 16 | X coordinate |
| req_y | input | 16 | Y coordinate |
| rsp_valid | output | 1 | Response registered from a request |
| rsp_ok | output | 1 | Format and coordinate were accepted |
| rsp_addr | output | 32 | Translated address, zero when rejected |
| rsp_stride | output | 32 | Row stride of the selected view |

## Verification
The assertions assume that `req_fmt` and `req_orient` hold known values whenever `req_valid` is high. The field checks compare the address against the request inputs one edge earlier, so they also rely on `req_valid` being sampled once per request. The coordinate inputs are 16 bits wide, so they can exceed every axis mask. For this reason the stimulus draws about a quarter of its coordinates over the full 16-bit range and the rest within the format's mask. Directed cases sit exactly on each mask and one step above it.

// File: rtl/tvat_pkg.sv
package tvat_pkg;

  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } tv_fmt_e;

  localparam int unsigned OR_MIRX = 0;
  localparam int unsigned OR_MIRY = 1;
  localparam int unsigned OR_SWAP = 2;

endpackage

// File: rtl/tvat_rst_sync.sv
module tvat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tvat_geom.sv
module tvat_geom #(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned BC_W    = 6
) (
  input  logic [1:0]      fmt,
  output logic            fmt_ok,
  output logic [1:0]      xdrop,
  output logic [1:0]      ydrop,
  output logic [BC_W-1:0] xbits,
  output logic [BC_W-1:0] ybits
);
  import tvat_pkg::*;

  always_comb begin
    fmt_ok = 1'b1;
    xdrop  = 2'd0;
    ydrop  = 2'd0;
    unique case (tv_fmt_e'(fmt))
      FMT_B8:   begin xdrop = 2'd0; ydrop = 2'd0; end
      FMT_B16:  begin xdrop = 2'd0; ydrop = 2'd1; end
      FMT_B32:  begin xdrop = 2'd1; ydrop = 2'd1; end
      default:  fmt_ok = 1'b0;
    endcase
    xbits = BC_W'(CW_BITS) - BC_W'(xdrop);
    ybits = BC_W'(CH_BITS) - BC_W'(ydrop);
  end
endmodule

// File: rtl/tvat_xform.sv
module tvat_xform #(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned COORD_W = 16,
  parameter int unsigned BC_W    = 6,
  localparam int unsigned IDX_W  = CW_BITS + CH_BITS,
  localparam int unsigned ADDR_W = IDX_W + 5
) (
  input  logic [1:0]        fmt,
  input  logic [2:0]        orient,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic              fmt_ok,
  input  logic [1:0]        xdrop,
  input  logic [1:0]        ydrop,
  input  logic [BC_W-1:0]   xbits,
  input  logic [BC_W-1:0]   ybits,
  output logic              ok,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] stride
);
  import tvat_pkg::*;

  logic [ADDR_W-1:0] xmask, ymask;
  logic              in_range;
  logic [IDX_W-1:0]  xv, yv, idx, scaled;
  logic [2:0]        align;
  logic [BC_W-1:0]   st_sh;

  always_comb begin
    xmask    = (ADDR_W'(1) << xbits) - ADDR_W'(1);
    ymask    = (ADDR_W'(1) << ybits) - ADDR_W'(1);
    in_range = (ADDR_W'(x) <= xmask) && (ADDR_W'(y) <= ymask);
    ok       = fmt_ok && in_range;

    xv = IDX_W'(x) ^ (orient[OR_MIRX] ? IDX_W'(xmask) : '0);
    yv = IDX_W'(y) ^ (orient[OR_MIRY] ? IDX_W'(ymask) : '0);

    if (orient[OR_SWAP]) idx = (xv << ybits) + yv;
    else                 idx = (yv << xbits) + xv;

    align  = {1'b0, xdrop} + {1'b0, ydrop};
    scaled = idx << align;

    addr = ok ? {orient, fmt, scaled} : '0;

    st_sh  = orient[OR_SWAP] ? (BC_W'(CH_BITS) + BC_W'(xdrop))
                             : (BC_W'(CW_BITS) + BC_W'(ydrop));
    stride = fmt_ok ? (ADDR_W'(1) << st_sh) : '0;
  end
endmodule

// File: rtl/tvat_outreg.sv
module tvat_outreg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              d_ok,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [ADDR_W-1:0] d_stride,
  output logic              q_valid,
  output logic              q_ok,
  output logic [ADDR_W-1:0] q_addr,
  output logic [ADDR_W-1:0] q_stride
);
  logic              ok_n;
  logic [ADDR_W-1:0] addr_n, stride_n;

  always_comb begin
    ok_n     = q_ok;
    addr_n   = q_addr;
    stride_n = q_stride;
    if (load) begin
      ok_n     = d_ok;
      addr_n   = d_addr;
      stride_n = d_stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_ok     <= 1'b0;
      q_addr   <= '0;
      q_stride <= '0;
    end else begin
      q_valid  <= load;
      q_ok     <= ok_n;
      q_addr   <= addr_n;
      q_stride <= stride_n;
    end
  end

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q_ok) && $stable(q_addr) && $stable(q_stride)));
endmodule

// File: rtl/tiled_view_xlate.sv
module tiled_view_xlate #(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned COORD_W = 16,
  localparam int unsigned IDX_W  = CW_BITS + CH_BITS,
  localparam int unsigned ADDR_W = IDX_W + 5,
  localparam int unsigned BC_W   = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_fmt,
  input  logic [2:0]         req_orient,
  input  logic [COORD_W-1:0] req_x,
  input  logic [COORD_W-1:0] req_y,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [ADDR_W-1:0]  rsp_stride
);
  logic              rst_i_n;
  logic              g_fmt_ok;
  logic [1:0]        g_xd, g_yd;
  logic [BC_W-1:0]   g_xb, g_yb;
  logic              x_ok;
  logic [ADDR_W-1:0] x_addr, x_stride;

  tvat_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  tvat_geom #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .BC_W(BC_W)) u_geom (
    .fmt(req_fmt), .fmt_ok(g_fmt_ok), .xdrop(g_xd), .ydrop(g_yd),
    .xbits(g_xb), .ybits(g_yb)
  );

  tvat_xform #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .COORD_W(COORD_W),
               .BC_W(BC_W)) u_xform (
    .fmt(req_fmt), .orient(req_orient), .x(req_x), .y(req_y),
    .fmt_ok(g_fmt_ok), .xdrop(g_xd), .ydrop(g_yd), .xbits(g_xb), .ybits(g_yb),
    .ok(x_ok), .addr(x_addr), .stride(x_stride)
  );

  tvat_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_i_n), .load(req_valid),
    .d_ok(x_ok), .d_addr(x_addr), .d_stride(x_stride),
    .q_valid(rsp_valid), .q_ok(rsp_ok), .q_addr(rsp_addr), .q_stride(rsp_stride)
  );

  // R4
  reject_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rsp_ok |-> (rsp_addr == '0));

  // R5
  page_reject_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_fmt == 2'd3) |=> (!rsp_ok && rsp_stride == '0));

  // R2
  fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> (!rsp_ok || rsp_addr[IDX_W +: 2] == $past(req_fmt)));

  // R3
  orient_field_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> (!rsp_ok || rsp_addr[IDX_W+2 +: 3] == $past(req_orient)));

  // R9
  stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |-> $onehot0(rsp_stride));

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/tiled_view_xlate_test.sv
module tiled_view_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_fmt;
  logic [2:0]  req_orient;
  logic [15:0] req_x, req_y;
  logic        rsp_valid, rsp_ok;
  logic [31:0] rsp_addr, rsp_stride;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  tiled_view_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
    .req_orient(req_orient), .req_x(req_x), .req_y(req_y),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
    .rsp_stride(rsp_stride)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic int xdrop_of(input int f);
    return (f == 2) ? 1 : 0;
  endfunction
  function automatic int ydrop_of(input int f);
    return (f == 1 || f == 2) ? 1 : 0;
  endfunction
  function automatic logic [31:0] xmask_of(input int f);
    return (32'd1 << (14 - xdrop_of(f))) - 32'd1;
  endfunction
  function automatic logic [31:0] ymask_of(input int f);
    return (32'd1 << (13 - ydrop_of(f))) - 32'd1;
  endfunction

  // expected {ok, addr, stride}
  function automatic logic [64:0] model(input int f, input logic [2:0] o,
                                         input logic [15:0] x, input logic [15:0] y);
    logic [31:0] xm, ym, xx, yy, idx, a, s;
    logic ok;
    int xd, yd;
    if (f == 3) return 65'd0;
    xd = xdrop_of(f); yd = ydrop_of(f);
    xm = xmask_of(f); ym = ymask_of(f);
    s  = o[2] ? (32'd1 << (13 + xd)) : (32'd1 << (14 + yd));
    ok = ({16'd0, x} <= xm) && ({16'd0, y} <= ym);
    if (!ok) return {1'b0, 32'd0, s};
    xx = o[0] ? ({16'd0, x} ^ xm) : {16'd0, x};
    yy = o[1] ? ({16'd0, y} ^ ym) : {16'd0, y};
    idx = o[2] ? ((xx << (13 - yd)) + yy) : ((yy << (14 - xd)) + xx);
    idx = idx << (xd + yd);
    a = ({29'd0, o} << 29) | (32'(f) << 27) | (idx & 32'h07FF_FFFF);
    return {1'b1, a, s};
  endfunction

  task automatic run_one(input string tag, input int f, input logic [2:0] o,
                         input logic [15:0] x, input logic [15:0] y);
    logic [64:0] e;
    e = model(f, o, x, y);
    @(negedge clk);
    req_valid = 1'b1; req_fmt = 2'(f); req_orient = o; req_x = x; req_y = y;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 valid", {31'd0, rsp_valid}, 32'd1);
    check({tag, " R4 ok"}, {31'd0, rsp_ok}, {31'd0, e[64]});
    check({tag, " addr"}, rsp_addr, e[63:32]);
    check("R9 stride", rsp_stride, e[31:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_a, hold_s;
    logic        hold_ok;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_fmt = '0; req_orient = '0;
    req_x = '0; req_y = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rst valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 rst ok", {31'd0, rsp_ok}, 32'd0);
    check("R1 rst addr", rsp_addr, 32'd0);
    check("R1 rst stride", rsp_stride, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_one("R7 origin", 0, 3'd0, 16'd0, 16'd0);
    run_one("R2 R8 b8 corner", 0, 3'd0, 16'd16383, 16'd8191);
    run_one("R4 b8 x over", 0, 3'd0, 16'd16384, 16'd0);
    run_one("R4 b8 y over", 0, 3'd0, 16'd0, 16'd8192);
    run_one("R8 b16 corner", 1, 3'd0, 16'd16383, 16'd4095);
    run_one("R4 b16 y over", 1, 3'd2, 16'd5, 16'd4096);
    run_one("R8 b32 corner", 2, 3'd4, 16'd8191, 16'd4095);
    run_one("R4 b32 x over", 2, 3'd6, 16'd8192, 16'd1);
    run_one("R5 page", 3, 3'd0, 16'd1, 16'd1);
    run_one("R5 page swap", 3, 3'd4, 16'd0, 16'd0);
    run_one("R6 mirror x", 0, 3'd1, 16'd0, 16'd3);
    run_one("R6 mirror y", 1, 3'd2, 16'd7, 16'd0);
    run_one("R7 swap", 2, 3'd4, 16'd100, 16'd200);
    run_one("R3 R6 R7 all", 1, 3'd7, 16'd12, 16'd34);
    for (int o = 0; o < 8; o++)
      run_one("R3 orient", 2, 3'(o), 16'd321, 16'd123);

    for (int i = 0; i < 400; i++) begin
      int f;
      logic [15:0] x, y;
      f = int'($urandom % 4);
      if ($urandom % 4 == 0) x = 16'($urandom);
      else x = 16'($urandom % (xmask_of(f) + 1));
      if ($urandom % 4 == 0) y = 16'($urandom);
      else y = 16'($urandom % (ymask_of(f) + 1));
      run_one("R6 R7 R8 rand", f, 3'($urandom), x, y);
    end

    // R10 idle hold
    run_one("R7 pre-hold", 1, 3'd5, 16'd77, 16'd88);
    hold_a = rsp_addr; hold_s = rsp_stride; hold_ok = rsp_ok;
    req_fmt = 2'd3; req_orient = 3'd2; req_x = 16'hFFFF; req_y = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1 idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R10 hold addr", rsp_addr, hold_a);
    check("R10 hold stride", rsp_stride, hold_s);
    check("R10 hold ok", {31'd0, rsp_ok}, {31'd0, hold_ok});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule